// File: doc/BRIEF.md
# Coherency Unit Register Block

This block is the software-visible register window of a multicore cache-coherency unit. It occupies 256 bytes on a simple synchronous register bus. That bus carries a request valid, a write flag, a byte address, 32-bit write data and four byte strobes. The block answers each request with a ready pulse and registered read data.

It holds three pieces of state:
- a one-bit enable register;
- a read-only configuration word that is worked out from the core-count parameter;
- a power-status word with one byte per core, which software can update one byte lane at a time.

Several other locations are decoded but hold nothing: the secure invalidate-all location and the two address-filter bounds. Every other offset is unimplemented. An access there returns zero, changes nothing, and raises a one-cycle flag that a monitor can log.

Top module: `scu_regs`

## Requirements
- R1: The core-count parameter `NCORE` must lie in 1..4. Any other value stops elaboration with a fatal error.
- R2: A request sampled at a rising edge is answered by `rsp_ready` high for exactly one cycle after that edge. `rsp_ready` is low in every other cycle.
- R3: The enable register at word offset 0x00 stores write-data bit 0 when strobe bit 0 is set. Bits 31..1 always read as zero.
- R4: Word offset 0x04 reads `((2^NCORE - 1) << 4) | (NCORE - 1)`. Writes to it change nothing.
- R5: The power-status word at 0x08 can be written through any byte address from 0x08 to 0x0B. Only the byte lanes whose strobe bit k is set take byte k of the write data. Byte k holds the power mode of core k, and a read returns all 32 bits.
- R6: Offset 0x0C reads as zero, accepts writes without effect and raises no flag.
- R7: Offsets 0x40 and 0x44 (the filter bounds) read as zero, ignore writes and raise no flag.
- R8: Every other word offset, including 0x50 and 0x54, reads as zero and discards writes. It raises `unimp_pulse` for one cycle, in the same cycle as `rsp_ready`.
- R9: Reset clears the enable register. The power-status word keeps its value across reset.
- R10: `rsp_rdata` is zero in every cycle except the response cycle of a read. A write response also carries zero.
- R11: Address bits 1..0 do not select a register: every byte address maps to the aligned 32-bit word that contains it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address within the window |
| req_wdata | input | 32 | Write data, aligned to word lanes |
| req_strb | input | 4 | Byte-lane write strobes |
| rsp_ready | output | 1 | Access complete (one cycle after the request) |
| rsp_rdata | output | 32 | Registered read data |
| unimp_pulse | output | 1 | One-cycle flag for an unimplemented offset |

## Verification
The bench runs with a three-core configuration. It sweeps all 256 byte addresses, writing all-ones and then reading back. This separates the three kinds of location: the decoded locations that hold nothing, the unimplemented ones that raise the flag, and the real registers. A later readback shows that no stray write reached the enable or power-status state.

All sixteen strobe patterns are applied to the power-status word through each of its byte addresses, to tell correct lane merging apart from whole-word overwrites. Writes with data bit 0 set and cleared, and a write with strobe 0 masked, show which bits the enable register keeps. A reset in the middle of the run shows that the enable register is cleared while the power-status word is kept.

// File: rtl/scu_regs.sv
module scu_regs #(
  parameter int NCORE = 4,
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [DW/8-1:0] req_strb,
  output logic            rsp_ready,
  output logic [DW-1:0]   rsp_rdata,
  output logic            unimp_pulse
);
  localparam int NB = DW / 8;
  localparam int WA = AW - 2;
  localparam logic [WA-1:0] W_CTRL = WA'(0);
  localparam logic [WA-1:0] W_CFG  = WA'(1);
  localparam logic [WA-1:0] W_PWR  = WA'(2);
  localparam logic [WA-1:0] W_INV  = WA'(3);
  localparam logic [WA-1:0] W_FLO  = WA'(16);
  localparam logic [WA-1:0] W_FHI  = WA'(17);
  localparam logic [DW-1:0] CFG_WORD = DW'((((1 << NCORE) - 1) << 4) | (NCORE - 1));

  // R1: core count range checked at elaboration
  if (NCORE < 1 || NCORE > 4) begin : g_bad_ncore
    $fatal(1, "scu_regs: NCORE must be 1..4");
  end

  logic [WA-1:0] widx;
  logic          known, wr, rd;
  logic          ctrl_q;
  logic [DW-1:0] pwr_q;
  logic [DW-1:0] rd_val;
  logic          unused_lo;

  assign widx      = req_addr[AW-1:2];
  assign unused_lo = &{1'b0, req_addr[1:0]};
  assign known     = (widx == W_CTRL) || (widx == W_CFG) || (widx == W_PWR) ||
                     (widx == W_INV)  || (widx == W_FLO) || (widx == W_FHI);
  assign wr        = req_valid && req_write;
  assign rd        = req_valid && !req_write;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                  ctrl_q <= 1'b0;
    else if (wr && widx == W_CTRL && req_strb[0]) ctrl_q <= req_wdata[0];

  for (genvar k = 0; k < NB; k++) begin : g_lane
    always_ff @(posedge clk)
      if (wr && widx == W_PWR && req_strb[k]) pwr_q[8*k +: 8] <= req_wdata[8*k +: 8];
  end

  always_comb begin
    rd_val = '0;
    case (widx)
      W_CTRL:  rd_val = DW'(ctrl_q);
      W_CFG:   rd_val = CFG_WORD;
      W_PWR:   rd_val = pwr_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_ready   <= 1'b0;
      rsp_rdata   <= '0;
      unimp_pulse <= 1'b0;
    end else begin
      rsp_ready   <= req_valid;
      rsp_rdata   <= rd ? rd_val : '0;
      unimp_pulse <= req_valid && !known;
    end

  a_r2_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);
  a_r2_ready_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> $past(req_valid));
  a_r8_flag_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    unimp_pulse |-> rsp_ready && rsp_rdata == '0);
  a_r8_no_state_change: assert property (@(posedge clk) disable iff (!rst_n)
    unimp_pulse |-> $stable(ctrl_q) && $stable(pwr_q));
  a_r3_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready && $past(rd && widx == W_CTRL) |-> rsp_rdata[DW-1:1] == '0);
  a_r4_cfg_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready && $past(rd && widx == W_CFG) |->
      32'(rsp_rdata[3:0]) + 32'd1 == 32'($countones(rsp_rdata[DW-1:4])));
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready |-> rsp_rdata == '0);
endmodule

// File: tb/tb_scu_regs.sv
module tb_scu_regs;
  localparam int N = 3;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_strb = '0;
  logic        rsp_ready, unimp_pulse;
  logic [31:0] rsp_rdata;
  int checks = 0, fails = 0;
  logic        m_ctrl;
  logic [31:0] m_pwr;

  always #2.5 clk = ~clk;

  scu_regs #(.NCORE(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .unimp_pulse(unimp_pulse));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic is_unimp(int w);
    return !(w == 0 || w == 1 || w == 2 || w == 3 || w == 16 || w == 17);
  endfunction

  function automatic logic [31:0] exp_rd(int w);
    case (w)
      0: return {31'd0, m_ctrl};
      1: return ((32'd1 << N) - 1) << 4 | 32'(N - 1);
      2: return m_pwr;
      default: return 32'd0;
    endcase
  endfunction

  task automatic access(logic wr, logic [7:0] a, logic [31:0] d, logic [3:0] s,
                        string r, output logic [31:0] data);
    int w = int'(a[7:2]);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_strb = s;
    @(negedge clk);
    req_valid = 1'b0;
    data = rsp_rdata;
    chk({r, "/R2 ready"}, 32'(rsp_ready), 32'd1);
    chk({r, "/R8 flag"}, 32'(unimp_pulse), 32'(is_unimp(w)));
    if (wr) begin
      chk({r, "/R10 write rdata"}, rsp_rdata, 32'd0);
      if (w == 0 && s[0]) m_ctrl = d[0];
      if (w == 2) for (int k = 0; k < 4; k++) if (s[k]) m_pwr[8*k +: 8] = d[8*k +: 8];
    end
    @(negedge clk);
    chk({r, "/R2 ready drops"}, 32'(rsp_ready), 32'd0);
    chk({r, "/R10 idle rdata"}, rsp_rdata, 32'd0);
  endtask

  task automatic rd_chk(logic [7:0] a, string r);
    logic [31:0] v;
    access(1'b0, a, 32'hx, 4'h0, r, v);
    chk(r, v, exp_rd(int'(a[7:2])));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] s, string r);
    logic [31:0] v;
    access(1'b1, a, d, s, r, v);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    m_ctrl = 1'b0; m_pwr = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset ready", 32'(rsp_ready), 32'd0);
    chk("R8 reset flag", 32'(unimp_pulse), 32'd0);
    chk("R10 reset rdata", rsp_rdata, 32'd0);
    rst_n = 1'b1;
    rd_chk(8'h00, "R9 ctrl after reset");
    wr(8'h08, 32'h0302_0100, 4'hF, "R5 full write");
    rd_chk(8'h08, "R5 full read");
    access(1'b0, 8'h04, 32'h0, 4'h0, "R1", v);
    chk("R1 core count field", 32'(v[3:0]) + 1, 32'(N));
    chk("R4 config", v, 32'h72);

    for (int b = 0; b < 4; b++) begin
      wr(8'(8 + b), 32'hA5A5_A5A5 ^ (32'h11 << (8 * b)), 4'(1 << b), "R5 lane");
      rd_chk(8'(8 + b), "R5 R11 lane read");
    end
    for (int s = 0; s < 16; s++) begin
      wr(8'h08 + 8'(s % 4), 32'h1000_0001 * 32'(s + 1) ^ 32'h5A3C_96E1, 4'(s), "R5 strobe");
      rd_chk(8'h08, "R5 strobe read");
    end

    wr(8'h00, 32'hFFFF_FFFE, 4'hF, "R3 clear");
    rd_chk(8'h00, "R3 bit0 zero");
    wr(8'h00, 32'hFFFF_FFFF, 4'hF, "R3 set");
    rd_chk(8'h00, "R3 bit0 one");
    wr(8'h00, 32'h0000_0000, 4'hE, "R3 masked");
    rd_chk(8'h00, "R3 masked keeps");
    wr(8'h04, 32'h0, 4'hF, "R4 write");
    rd_chk(8'h04, "R4 write ignored");
    wr(8'h0C, 32'hFFFF_FFFF, 4'hF, "R6 write");
    rd_chk(8'h0C, "R6 read zero");
    wr(8'h40, 32'hFFFF_FFFF, 4'hF, "R7 lo write");
    wr(8'h44, 32'hFFFF_FFFF, 4'hF, "R7 hi write");
    rd_chk(8'h40, "R7 lo zero");
    rd_chk(8'h44, "R7 hi zero");
    wr(8'h50, 32'hFFFF_FFFF, 4'hF, "R8 0x50");
    wr(8'h54, 32'hFFFF_FFFF, 4'hF, "R8 0x54");
    rd_chk(8'h50, "R8 0x50 zero");
    rd_chk(8'h00, "R8 ctrl untouched");
    rd_chk(8'h08, "R8 pwr untouched");

    for (int a = 0; a < 256; a++) begin
      if (a[7:2] != 6'd0 && a[7:2] != 6'd2)
        wr(8'(a), 32'hFFFF_FFFF, 4'hF, "R8 sweep write");
      rd_chk(8'(a), "R11 R6 R7 R8 sweep read");
    end
    rd_chk(8'h00, "R8 sweep ctrl kept");
    rd_chk(8'h08, "R8 sweep pwr kept");

    wr(8'h08, 32'hDEAD_BEEF, 4'hF, "R9 pwr set");
    wr(8'h00, 32'h1, 4'h1, "R9 ctrl set");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_ctrl = 1'b0;
    rd_chk(8'h00, "R9 ctrl cleared");
    rd_chk(8'h08, "R9 pwr kept");
    chk("R9 pwr value", m_pwr, 32'hDEAD_BEEF);
    summary();
  end
endmodule